// File: doc/BRIEF.md
# Taillight Sequencing Controller

This block turns four driver switch levels (left turn, right turn, hazard and brake) into six lamp outputs, with three lamps on each side of the vehicle. A turn request runs a chase on the matching side. Each step lights the next lamp outward from the centre line. The chase runs from the inner lamp to the outer lamp on both sides, so the two sides move in opposite directions in the vehicle's own frame. A hazard request blinks all six lamps together. A brake request, or both turn switches at once, holds all six lamps on.

The animation rate comes from a one-cycle step tick that is generated elsewhere. The switches come from slow mechanical sources, so each one passes through a two-stage synchronizer before it is used. A fixed priority decides which request wins, and the pattern then runs from registered state. Debouncing, lamp drivers and tick generation belong to the surrounding logic.

Top module: `tail_lamp_ctrl`

## Requirements
- R1: While `rst_i` is high, every lamp output is 0 on the following clock edge, and the synchronizers and pattern state are cleared.
- R2: With no switch active, all six lamps are off, and step ticks do not change that.
- R3: With only the left switch active, the right lamps stay 0 and the left lamps step 000, 001, 010, 100. Bit 0 is the innermost lamp and bit 2 the outermost.
- R4: With only the right switch active, the left lamps stay 0 and the right lamps step through the same inner-to-outer sequence, with bit 0 innermost.
- R5: After the outermost lamp of a chase, the next tick returns that side to all-off, and the chase then starts again.
- R6: With hazard winning, all six lamps are dark when the mode is entered. Each tick then flips all six together, between all-on and all-off.
- R7: With brake active, all six lamps are on and stay on through any number of ticks.
- R8: With left and right both active, all six lamps are on, the same as brake.
- R9: Priority runs from brake (or both turns), to hazard, to a single turn, to idle.
- R10: When the winning request changes, or after reset, the pattern restarts from its all-off state. It advances only on a later tick.
- R11: Pattern state changes only on cycles where `step_i` is high. A tick held high for several cycles advances the pattern once per cycle.
- R12: A switch change shows on the lamps on the third rising clock edge after it. A tick shows on the first rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| step_i | input | 1 | Animation step tick, one cycle per step |
| turn_l_i | input | 1 | Left turn switch level (asynchronous) |
| turn_r_i | input | 1 | Right turn switch level (asynchronous) |
| hazard_i | input | 1 | Hazard/fault switch level (asynchronous) |
| brake_i | input | 1 | Brake switch level (asynchronous) |
| lamp_l_o | output | 3 | Left lamps, bit 0 innermost |
| lamp_r_o | output | 3 | Right lamps, bit 0 innermost |

## Verification
The stability and steady-brake assertions assume that a switch level held unchanged for three cycles has reached the pattern logic. They also assume that `step_i` is already synchronous to the clock. They are checked only once four cycles have passed since reset. The bench drives all inputs on the falling edge and holds every switch pattern for four cycles with the tick low before it issues ticks. Every compared value therefore comes from a settled request.

// File: rtl/tl_pkg.sv
package tl_pkg;

    typedef enum logic [2:0] {
        MODE_IDLE  = 3'd0,
        MODE_LEFT  = 3'd1,
        MODE_RIGHT = 3'd2,
        MODE_FLASH = 3'd3,
        MODE_SOLID = 3'd4
    } lamp_mode_e;

    localparam int SW_W = 4;

endpackage

// File: rtl/tl_sync.sv
module tl_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            logic [WIDTH-1:0] src_d;
            if (s == 0) begin : g_first
                assign src_d = async_i;
            end else begin : g_next
                assign src_d = stage_q[s-1];
            end
            always_ff @(posedge clk_i) begin
                if (rst_i) stage_q[s] <= '0;
                else       stage_q[s] <= src_d;
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/tl_arbiter.sv
module tl_arbiter
    import tl_pkg::*;
(
    input  logic       left_i,
    input  logic       right_i,
    input  logic       hazard_i,
    input  logic       brake_i,
    output lamp_mode_e mode_o
);

    always_comb begin
        if (brake_i || (left_i && right_i)) mode_o = MODE_SOLID;
        else if (hazard_i)                  mode_o = MODE_FLASH;
        else if (left_i)                    mode_o = MODE_LEFT;
        else if (right_i)                   mode_o = MODE_RIGHT;
        else                                mode_o = MODE_IDLE;
    end

endmodule

// File: rtl/tl_pattern.sv
module tl_pattern
    import tl_pkg::*;
#(
    parameter int NUM_LAMPS = 3
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 step_i,
    input  lamp_mode_e           mode_i,
    output logic [NUM_LAMPS-1:0] left_o,
    output logic [NUM_LAMPS-1:0] right_o
);

    localparam int               POS_W = $clog2(NUM_LAMPS + 1);
    localparam logic [POS_W-1:0] LAST  = POS_W'(NUM_LAMPS);

    typedef struct packed {
        lamp_mode_e           mode;
        logic [POS_W-1:0]     pos;
        logic                 flash;
        logic [NUM_LAMPS-1:0] left;
        logic [NUM_LAMPS-1:0] right;
    } pat_state_t;

    pat_state_t state_d, state_q;
    logic [NUM_LAMPS-1:0] chase_d;

    generate
        for (genvar i = 0; i < NUM_LAMPS; i++) begin : g_chase
            assign chase_d[i] = (state_d.pos == POS_W'(i + 1));
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        if (mode_i != state_q.mode) begin
            state_d.mode  = mode_i;
            state_d.pos   = '0;
            state_d.flash = 1'b0;
        end else if (step_i) begin
            unique case (state_q.mode)
                MODE_LEFT, MODE_RIGHT:
                    state_d.pos = (state_q.pos == LAST) ? '0 : state_q.pos + 1'b1;
                MODE_FLASH:
                    state_d.flash = ~state_q.flash;
                default: ;
            endcase
        end

        state_d.left  = '0;
        state_d.right = '0;
        unique case (state_d.mode)
            MODE_SOLID: begin
                state_d.left  = '1;
                state_d.right = '1;
            end
            MODE_FLASH: begin
                state_d.left  = {NUM_LAMPS{state_d.flash}};
                state_d.right = {NUM_LAMPS{state_d.flash}};
            end
            MODE_LEFT:  state_d.left  = chase_d;
            MODE_RIGHT: state_d.right = chase_d;
            default: ;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q.mode  <= MODE_IDLE;
            state_q.pos   <= '0;
            state_q.flash <= 1'b0;
            state_q.left  <= '0;
            state_q.right <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign left_o  = state_q.left;
    assign right_o = state_q.right;

endmodule

// File: rtl/tail_lamp_ctrl.sv
module tail_lamp_ctrl
    import tl_pkg::*;
#(
    parameter int NUM_LAMPS   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 step_i,
    input  logic                 turn_l_i,
    input  logic                 turn_r_i,
    input  logic                 hazard_i,
    input  logic                 brake_i,
    output logic [NUM_LAMPS-1:0] lamp_l_o,
    output logic [NUM_LAMPS-1:0] lamp_r_o
);

    logic [SW_W-1:0] sw_sync;
    lamp_mode_e      mode_win;

    tl_sync #(
        .WIDTH  (SW_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i ({brake_i, hazard_i, turn_l_i, turn_r_i}),
        .sync_o  (sw_sync)
    );

    tl_arbiter u_arb (
        .left_i   (sw_sync[1]),
        .right_i  (sw_sync[0]),
        .hazard_i (sw_sync[2]),
        .brake_i  (sw_sync[3]),
        .mode_o   (mode_win)
    );

    tl_pattern #(
        .NUM_LAMPS (NUM_LAMPS)
    ) u_pat (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .step_i  (step_i),
        .mode_i  (mode_win),
        .left_o  (lamp_l_o),
        .right_o (lamp_r_o)
    );

endmodule

// File: rtl/tail_lamp_ctrl_chk.sv
module tail_lamp_ctrl_chk #(
    parameter int NUM_LAMPS = 3
) (
    input logic                 clk_i,
    input logic                 rst_i,
    input logic                 step_i,
    input logic                 turn_l_i,
    input logic                 turn_r_i,
    input logic                 hazard_i,
    input logic                 brake_i,
    input logic [NUM_LAMPS-1:0] lamp_l_o,
    input logic [NUM_LAMPS-1:0] lamp_r_o
);

    logic [3:0] sw;
    logic [2:0] age_q;
    logic       settled;

    assign sw      = {brake_i, hazard_i, turn_l_i, turn_r_i};
    assign settled = (age_q == 3'd4);

    always_ff @(posedge clk_i) begin
        if (rst_i)        age_q <= '0;
        else if (!settled) age_q <= age_q + 1'b1;
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk_i)
        rst_i |=> (lamp_l_o == '0 && lamp_r_o == '0));

    // R3
    side_shape_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (lamp_l_o != '0 && lamp_r_o == '0) |-> $onehot0(lamp_l_o));

    // R4
    side_exclusive_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (lamp_l_o != '0 && lamp_r_o != '0) |-> (&lamp_l_o && &lamp_r_o));

    // R11
    hold_without_tick_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (settled && !step_i && $stable(sw) && $past(sw) == $past(sw, 2)
         && $past(sw, 2) == $past(sw, 3))
        |=> ($stable(lamp_l_o) && $stable(lamp_r_o)));

    // R7
    brake_steady_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (settled && brake_i && $past(brake_i) && $past(brake_i, 2))
        |=> (&lamp_l_o && &lamp_r_o));

endmodule

bind tail_lamp_ctrl tail_lamp_ctrl_chk #(.NUM_LAMPS(NUM_LAMPS)) u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .step_i   (step_i),
    .turn_l_i (turn_l_i),
    .turn_r_i (turn_r_i),
    .hazard_i (hazard_i),
    .brake_i  (brake_i),
    .lamp_l_o (lamp_l_o),
    .lamp_r_o (lamp_r_o)
);

// File: tb/tail_lamp_ctrl_tb.sv
module tail_lamp_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step = 1'b0;
    logic       tl = 1'b0, tr = 1'b0, hz = 1'b0, br = 1'b0;
    logic [2:0] lamp_l, lamp_r;
    int         n_cmp = 0;
    int         n_bad = 0;

    always #2 clk = ~clk;

    tail_lamp_ctrl u_dut (
        .clk_i    (clk),
        .rst_i    (rst),
        .step_i   (step),
        .turn_l_i (tl),
        .turn_r_i (tr),
        .hazard_i (hz),
        .brake_i  (br),
        .lamp_l_o (lamp_l),
        .lamp_r_o (lamp_r)
    );

    // {brake, hazard, left, right} ticks expL expR
    localparam int NV = 22;
    localparam logic [12:0] VEC [NV] = '{
        {4'b0000, 3'd0, 3'b000, 3'b000},
        {4'b0010, 3'd0, 3'b000, 3'b000},
        {4'b0010, 3'd1, 3'b001, 3'b000},
        {4'b0010, 3'd1, 3'b010, 3'b000},
        {4'b0010, 3'd1, 3'b100, 3'b000},
        {4'b0010, 3'd1, 3'b000, 3'b000},
        {4'b0010, 3'd2, 3'b010, 3'b000},
        {4'b0001, 3'd0, 3'b000, 3'b000},
        {4'b0001, 3'd1, 3'b000, 3'b001},
        {4'b0001, 3'd3, 3'b000, 3'b000},
        {4'b0001, 3'd2, 3'b000, 3'b010},
        {4'b0100, 3'd0, 3'b000, 3'b000},
        {4'b0100, 3'd1, 3'b111, 3'b111},
        {4'b0100, 3'd1, 3'b000, 3'b000},
        {4'b0100, 3'd3, 3'b111, 3'b111},
        {4'b1000, 3'd0, 3'b111, 3'b111},
        {4'b1000, 3'd5, 3'b111, 3'b111},
        {4'b0011, 3'd0, 3'b111, 3'b111},
        {4'b0110, 3'd1, 3'b111, 3'b111},
        {4'b1100, 3'd0, 3'b111, 3'b111},
        {4'b0000, 3'd3, 3'b000, 3'b000},
        {4'b0111, 3'd0, 3'b111, 3'b111}
    };
    localparam string TAG [NV] = '{
        "R2", "R10", "R3", "R3", "R3", "R5", "R5", "R10", "R4", "R5", "R4",
        "R6", "R6", "R6", "R6", "R7", "R7", "R8", "R9", "R9", "R2", "R9"
    };

    task automatic check(input string req, input logic [2:0] el, input logic [2:0] er);
        n_cmp++;
        if (lamp_l !== el || lamp_r !== er) begin
            n_bad++;
            $display("FAIL %s: got L=%b R=%b expected L=%b R=%b", req, lamp_l, lamp_r, el, er);
        end
    endtask

    task automatic set_sw(input logic [3:0] s);
        {br, hz, tl, tr} = s;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            step = 1'b1;
            @(negedge clk);
            step = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 3'b000, 3'b000);
        rst = 1'b0;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            set_sw(VEC[v][12:9]);
            settle();
            ticks(int'(VEC[v][8:6]));
            check(TAG[v], VEC[v][5:3], VEC[v][2:0]);
        end

        // R12: switch latency of three edges
        set_sw(4'b0000);
        settle();
        set_sw(4'b1000);
        repeat (2) @(negedge clk);
        check("R12", 3'b000, 3'b000);
        @(negedge clk);
        check("R12", 3'b111, 3'b111);

        // R11: held tick advances once per cycle
        set_sw(4'b0010);
        settle();
        step = 1'b1;
        repeat (2) @(negedge clk);
        step = 1'b0;
        check("R11", 3'b010, 3'b000);

        // R12: tick seen on the first edge
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        check("R12", 3'b100, 3'b000);

        // R1 mid-pattern reset, then R10 restart
        rst = 1'b1;
        @(negedge clk);
        check("R1", 3'b000, 3'b000);
        rst = 1'b0;
        settle();
        check("R10", 3'b000, 3'b000);
        ticks(1);
        check("R10", 3'b001, 3'b000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #800000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got hung run expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule